// File: doc/BRIEF.md
# Shared-Port Memory Card Page Selector

This block is the bank-select logic of one memory expansion card on an 8-bit microprocessor bus. All cards in the system listen on the same I/O port. A byte written to that port holds a card identity in its upper bits and a page number in its lower bits. Each card compares the identity part with the value strapped into it. The card whose identity matches becomes the selected card and stores the page part. Every other card drops out. This gives software one flat page numbering that spans all cards, so it never needs to know which card holds which page.

Once selected, the card serves memory requests in the upper 32 KiB window, 8000h to FFFFh. It does this by raising the chip select of the stored page. It also pulls the shared, normally pulled-up line that turns off the internal memory. A read of the bank port is answered only by the selected card, which returns its identity and its current page. The parameter `PAGE_BITS` sets where the byte splits between identity and page, and so it follows the number of pages the card holds.

Top module: `card_page_decoder`

## Requirements
- R1: After reset the card is not selected. No chip select is active, the internal-memory disable is not driven, and a port read leaves `dout_oe` low.
- R2: A port write is a cycle with `iorq_n` low, `m1_n` high, `wr_n` low and `addr_lo` equal to `PORT_ADDR`. When the data bits [7:PAGE_BITS] equal `CARD_ID`, the card becomes selected and stores data bits [PAGE_BITS-1:0] as its page. The change takes effect on the first clock edge after the write strobe ends.
- R3: A port write whose identity bits do not equal `CARD_ID` deselects the card, whatever its earlier state.
- R4: A write with `addr_lo` other than `PORT_ADDR` has no effect on the selection or on the stored page.
- R5: An I/O cycle with `m1_n` low (interrupt acknowledge) has no effect, even when the address and data would otherwise match.
- R6: A port read (`iorq_n` low, `m1_n` high, `rd_n` low, matching address) while the card is selected raises `dout_oe`, and `dout` equals {CARD_ID, page}. While the card is not selected, `dout_oe` stays low.
- R7: While the card is selected, a memory request (`mreq_n` low) with `a15` high raises exactly bit `page` of `page_cs` and raises `int_off_drive`. With `a15` low, or with the card not selected, all of `page_cs` and `int_off_drive` stay low.
- R8: With the defaults (PAGE_BITS=1, CARD_ID=03h), the bytes 06h and 07h select pages 0 and 1. Every other byte value deselects the card.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for the bus strobes |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr_lo | input | 8 | Low address byte (I/O port number) |
| a15 | input | 1 | Address bit 15, selects the mapped window |
| din | input | 8 | Data bus into the card |
| iorq_n | input | 1 | I/O request, active low |
| mreq_n | input | 1 | Memory request, active low |
| m1_n | input | 1 | Opcode fetch / interrupt acknowledge marker, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| dout | output | 8 | Readback byte: identity and page |
| dout_oe | output | 1 | Output enable for the data bus driver |
| page_cs | output | 2**PAGE_BITS | One chip select per page, active high |
| int_off_drive | output | 1 | When high, the open-drain driver pulls the internal-memory disable line low |

## Verification
The bench writes each of the 256 byte values to the port in turn. After each write it checks the window chip selects, the internal-memory disable and the readback. A card that compared one bit too few or too many would claim the wrong pages. A card that kept its selection on a mismatch would go on answering after 08h follows 07h. Writes to a neighbouring port and interrupt-acknowledge cycles are also sent to a selected card. A decoder that ignored the address or `m1_n` would then lose its page. Reads on an unselected card must leave the bus undriven, because a card that drove it there would collide with the card that owns the page.

// File: rtl/card_page_decoder.sv
module card_page_decoder #(
  parameter int         PAGE_BITS = 1,
  parameter logic [7:0] PORT_ADDR = 8'hF0,
  parameter logic [7:0] CARD_ID   = 8'h03
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [7:0]                addr_lo,
  input  logic                      a15,
  input  logic [7:0]                din,
  input  logic                      iorq_n,
  input  logic                      mreq_n,
  input  logic                      m1_n,
  input  logic                      rd_n,
  input  logic                      wr_n,
  output logic [7:0]                dout,
  output logic                      dout_oe,
  output logic [(1<<PAGE_BITS)-1:0] page_cs,
  output logic                      int_off_drive
);
  localparam int ID_W  = 8 - PAGE_BITS;
  localparam int PAGES = 1 << PAGE_BITS;

  logic                 port_hit, port_wr, port_rd;
  logic                 wr_q, sel_q, id_match, win;
  logic [7:0]           data_q;
  logic [PAGE_BITS-1:0] page_q;

  assign port_hit = !iorq_n && m1_n && (addr_lo == PORT_ADDR);
  assign port_wr  = port_hit && !wr_n;
  assign port_rd  = port_hit && !rd_n;
  assign id_match = data_q[7:PAGE_BITS] == CARD_ID[ID_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= 1'b0;
      data_q <= '0;
      sel_q  <= 1'b0;
      page_q <= '0;
    end else begin
      wr_q <= port_wr;
      if (port_wr) data_q <= din;
      if (wr_q && !port_wr) begin
        sel_q <= id_match;
        if (id_match) page_q <= data_q[PAGE_BITS-1:0];
      end
    end
  end

  assign win           = sel_q && !mreq_n && a15;
  assign int_off_drive = win;
  assign dout          = {CARD_ID[ID_W-1:0], page_q};
  assign dout_oe       = sel_q && port_rd;

  for (genvar g = 0; g < PAGES; g++) begin : g_cs
    assign page_cs[g] = win && (page_q == PAGE_BITS'(g));
  end

  p_idle_after_reset_r1: assert property (@(posedge clk)
    $rose(rst_n) |-> !int_off_drive && !dout_oe);

  p_sel_moves_after_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sel_q) |-> $past(wr_q));

  p_page_moves_after_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(page_q) |-> $past(wr_q));

  p_readback_needs_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dout_oe |-> (!rd_n && m1_n && !iorq_n));

  p_cs_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(page_cs));

  p_cs_tracks_disable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|page_cs) == int_off_drive);

  p_window_only_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    int_off_drive |-> (a15 && !mreq_n));
endmodule

// File: tb/sim_card_page_decoder.sv
module sim_card_page_decoder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] addr_lo = 8'h00;
  logic a15 = 1'b0;
  logic [7:0] din = 8'h00;
  logic iorq_n = 1'b1, mreq_n = 1'b1, m1_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [7:0] dout;
  logic dout_oe;
  logic [1:0] page_cs;
  logic int_off_drive;
  int n_checks = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  card_page_decoder u0 (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] port, input logic [7:0] d, input logic m1v);
    @(negedge clk);
    addr_lo = port; din = d; m1_n = m1v; iorq_n = 1'b0; wr_n = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    iorq_n = 1'b1; wr_n = 1'b1; m1_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic observe(input bit sel, input int page, input logic [7:0] id_byte, input string tag);
    @(negedge clk);
    mreq_n = 1'b0; a15 = 1'b1; #1;
    chk(page_cs == (sel ? 2'(1 << page) : 2'b00), {tag, " R7 cs"}, page_cs, sel ? (1 << page) : 0);
    chk(int_off_drive == sel, {tag, " R7 disable"}, int_off_drive, sel);
    a15 = 1'b0; #1;
    chk(page_cs == 2'b00 && !int_off_drive, {tag, " R7 low half"}, {page_cs, int_off_drive}, 0);
    mreq_n = 1'b1;
    @(negedge clk);
    addr_lo = 8'hF0; iorq_n = 1'b0; rd_n = 1'b0; #1;
    chk(dout_oe == sel, {tag, " R6 oe"}, dout_oe, sel);
    if (sel) chk(dout == id_byte, {tag, " R6 data"}, dout, id_byte);
    iorq_n = 1'b1; rd_n = 1'b1;
  endtask

  initial begin
    #(8 * 190000);
    chk(1'b0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    observe(1'b0, 0, 8'h00, "R1 reset");
    // R2 R3 R8: sweep every byte value
    for (int d = 0; d < 256; d++) begin
      bit es;
      es = ((d >> 1) == 3);
      bus_write(8'hF0, 8'(d), 1'b1);
      observe(es, d & 1, 8'(d), es ? "R2 R8 match" : "R3 R8 mismatch");
    end
    bus_write(8'hF0, 8'h07, 1'b1);
    observe(1'b1, 1, 8'h07, "R2 reselect");
    bus_write(8'hF1, 8'h00, 1'b1);
    observe(1'b1, 1, 8'h07, "R4 other port");
    bus_write(8'h70, 8'h06, 1'b1);
    observe(1'b1, 1, 8'h07, "R4 other port page");
    bus_write(8'hF0, 8'h06, 1'b0);
    observe(1'b1, 1, 8'h07, "R5 intack");
    bus_write(8'hF0, 8'h06, 1'b1);
    observe(1'b1, 0, 8'h06, "R2 page0");
    bus_write(8'hF0, 8'h05, 1'b1);
    observe(1'b0, 0, 8'h00, "R3 drop");
    bus_write(8'hF0, 8'h06, 1'b0);
    observe(1'b0, 0, 8'h00, "R5 intack no select");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule